// File: doc/BRIEF.md
# Tiled Point-Source Hologram Accumulator

This block builds one square tile of a complex computer-generated hologram. The caller streams object points into it. Each point has a position, a reciprocal depth and an amplitude. For every point, all pixels of the tile are evaluated at once. Each pixel's fringe term comes from its squared distance to the point, using a quadratic (Fresnel) phase model. The terms are added into per-pixel real and imaginary accumulators.

When the point flagged last has been added, the block stops taking points. It then streams the finished tile out one pixel per handshake, in raster order. A larger hologram is produced by running the block once per tile, with a different tile origin each time.

Top module: `holo_tile_acc`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: The pixel in row r and column c (0..11) sits at `org_x + c`, `org_y + r`, with both sums wrapped to 12-bit signed. dx and dy are the pixel coordinate minus the point coordinate, as exact 13-bit signed values. The 10-bit phase index is bits [25:16] of (dx² + dy²) × `in_invz`.
- R3: The quarter-wave value for index t (0..255) is floor(t·(512−t)·32767 / 65536). For a phase index p, let q = p[9:8] and i = p[7:0]. The magnitude is taken at i when q[0] is 0 and at 255−i when q[0] is 1. The sign is negative when q[1] is 1. The imaginary part uses the sine of p, and the real part uses the sine of (p+256) mod 1024.
- R4: Each point adds floor(`in_amp` × value / 128) to each pixel's real and imaginary accumulators, and the tile is the sum over all points.
- R5: The first point of a tile replaces the accumulator contents, so a tile never carries values left over from the previous tile.
- R6: Accumulators are 24-bit signed and saturate at +8388607 and −8388608.
- R7: If the last point is accepted at clock edge k, `out_valid` is 0 between edges k and k+1 and is 1 after edge k+1.
- R8: `in_ready` is 0 from the edge that accepts the last point until readout ends.
- R9: Pixels are read out in raster order (index r·12+c). An unaccepted pixel holds its data and its `out_valid`.
- R10: `out_last` is 1 only on pixel 143. After that pixel's handshake, `in_ready` is 1 and `out_valid` is 0.
- R11: The tile origin is sampled only when the first point of a tile is accepted. Origin inputs seen with later points have no effect.
- R12: For a single point lying on pixel column 5 of the tile, columns 5−a and 5+a hold identical values (a = 1..5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Object point present |
| in_ready | output | 1 | Block can take a point |
| in_x | input | 12 | Point x, signed |
| in_y | input | 12 | Point y, signed |
| in_invz | input | 16 | Reciprocal depth, unsigned fixed point |
| in_amp | input | 8 | Point amplitude, unsigned |
| in_last | input | 1 | Final point of the tile |
| org_x | input | 12 | Tile origin x, signed |
| org_y | input | 12 | Tile origin y, signed |
| out_valid | output | 1 | Tile pixel present |
| out_ready | input | 1 | Sink takes the pixel |
| out_re | output | 24 | Real part, signed |
| out_im | output | 24 | Imaginary part, signed |
| out_last | output | 1 | Final pixel of the tile |

## Verification
An accepted point lands in a stage register at its accepting edge and reaches the accumulators one edge later. The bench therefore expects `in_ready` to be low at the first falling edge after the last point is taken, with `out_valid` still low. It expects `out_valid` high one falling edge later. All inputs are driven and all outputs sampled on falling edges, so each registered result is read half a period after the edge that produced it. During readout, the bench re-checks the same pixel at every falling edge until `out_ready` has been high across a rising edge. This shows that stalled pixels hold their values.

// File: rtl/holo_pkg.sv
package holo_pkg;
    parameter int unsigned CW     = 12;
    parameter int unsigned ZW     = 16;
    parameter int unsigned AMPW   = 8;
    parameter int unsigned AW     = 24;
    parameter int unsigned TILE   = 12;
    parameter int unsigned PH_LSB = 16;
    parameter int unsigned CSHIFT = 7;

    localparam int unsigned NPIX  = TILE * TILE;
    localparam int unsigned IDXW  = $clog2(NPIX);
    localparam int unsigned DW    = CW + 1;
    localparam int unsigned D2W   = 2 * DW;
    localparam int unsigned PRODW = D2W + ZW;
    localparam int unsigned PHW   = 10;
    localparam int unsigned TRW   = 17;
    localparam int unsigned TERMW = AMPW + 1 + TRW;
    localparam int unsigned SUMW  = TERMW + 2;
    localparam longint      ACC_HI = (longint'(1) <<< (AW - 1)) - 1;
    localparam longint      ACC_LO = -(longint'(1) <<< (AW - 1));

    typedef struct packed {
        logic signed [CW-1:0] x;
        logic signed [CW-1:0] y;
        logic [ZW-1:0]        invz;
        logic [AMPW-1:0]      amp;
    } point_t;

    typedef enum logic {ST_ACCEPT, ST_READ} state_e;

    function automatic logic signed [AW-1:0] sat_add(
        input logic signed [AW-1:0]    a,
        input logic signed [TERMW-1:0] c
    );
        logic signed [SUMW-1:0] s;
        s = SUMW'(a) + SUMW'(c);
        if (s > ACC_HI)      return AW'(ACC_HI);
        else if (s < ACC_LO) return AW'(ACC_LO);
        else                 return AW'(s);
    endfunction
endpackage

// File: rtl/holo_sine.sv
module holo_sine
    import holo_pkg::*;
(
    input  logic [PHW-1:0]        ph,
    output logic signed [TRW-1:0] val
);
    function automatic logic [14:0] quarter(input logic [7:0] t);
        logic [32:0] p;
        p = 33'(t) * (33'd512 - 33'(t)) * 33'd32767;
        return p[30:16];
    endfunction

    logic [14:0] mag;

    always_comb begin
        mag = ph[PHW-2] ? quarter(~ph[7:0]) : quarter(ph[7:0]);
        val = ph[PHW-1] ? -$signed({2'b00, mag}) : $signed({2'b00, mag});
    end
endmodule

// File: rtl/holo_pixel.sv
module holo_pixel
    import holo_pkg::*;
#(
    parameter int OFFX = 0,
    parameter int OFFY = 0
) (
    input  point_t                  pt,
    input  logic signed [CW-1:0]    ox,
    input  logic signed [CW-1:0]    oy,
    output logic signed [TERMW-1:0] c_re,
    output logic signed [TERMW-1:0] c_im
);
    logic signed [CW-1:0]    px_d, py_d;
    logic signed [DW-1:0]    dx_d, dy_d;
    logic signed [D2W-1:0]   sqx_d, sqy_d;
    logic [D2W-1:0]          d2_d;
    logic [PRODW-1:0]        prod_d;
    logic [PHW-1:0]          ph_d, phc_d;
    logic signed [TRW-1:0]   sin_v, cos_v;
    logic signed [TERMW-1:0] tre_d, tim_d;

    always_comb begin
        px_d   = ox + CW'(OFFX);
        py_d   = oy + CW'(OFFY);
        dx_d   = DW'(px_d) - DW'(pt.x);
        dy_d   = DW'(py_d) - DW'(pt.y);
        sqx_d  = dx_d * dx_d;
        sqy_d  = dy_d * dy_d;
        d2_d   = D2W'(sqx_d) + D2W'(sqy_d);
        prod_d = PRODW'(d2_d) * PRODW'(pt.invz);
        ph_d   = prod_d[PH_LSB +: PHW];
        phc_d  = ph_d + PHW'(256);
        tre_d  = $signed({1'b0, pt.amp}) * cos_v;
        tim_d  = $signed({1'b0, pt.amp}) * sin_v;
        c_re   = tre_d >>> CSHIFT;
        c_im   = tim_d >>> CSHIFT;
    end

    holo_sine u_sin (.ph(ph_d),  .val(sin_v));
    holo_sine u_cos (.ph(phc_d), .val(cos_v));
endmodule

// File: rtl/holo_tile_acc.sv
module holo_tile_acc
    import holo_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic signed [CW-1:0] in_x,
    input  logic signed [CW-1:0] in_y,
    input  logic [ZW-1:0]        in_invz,
    input  logic [AMPW-1:0]      in_amp,
    input  logic                 in_last,
    input  logic signed [CW-1:0] org_x,
    input  logic signed [CW-1:0] org_y,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic signed [AW-1:0] out_re,
    output logic signed [AW-1:0] out_im,
    output logic                 out_last
);
    typedef struct packed {
        state_e                      st;
        logic                        s1_vld;
        logic                        s1_last;
        logic                        s1_first;
        logic                        fresh;
        point_t                      pt;
        logic signed [CW-1:0]        ox;
        logic signed [CW-1:0]        oy;
        logic [IDXW-1:0]             rd_idx;
        logic [NPIX-1:0][AW-1:0]     acc_re;
        logic [NPIX-1:0][AW-1:0]     acc_im;
    } state_t;

    state_t q, d;
    logic signed [TERMW-1:0] c_re [NPIX];
    logic signed [TERMW-1:0] c_im [NPIX];

    for (genvar r = 0; r < TILE; r++) begin : g_row
        for (genvar c = 0; c < TILE; c++) begin : g_col
            holo_pixel #(.OFFX(c), .OFFY(r)) u_px (
                .pt  (q.pt),
                .ox  (q.ox),
                .oy  (q.oy),
                .c_re(c_re[r*TILE+c]),
                .c_im(c_im[r*TILE+c])
            );
        end
    end

    always_comb begin
        in_ready  = (q.st == ST_ACCEPT) && !(q.s1_vld && q.s1_last);
        out_valid = (q.st == ST_READ);
        out_re    = $signed(q.acc_re[q.rd_idx]);
        out_im    = $signed(q.acc_im[q.rd_idx]);
        out_last  = out_valid && (q.rd_idx == IDXW'(NPIX - 1));
    end

    always_comb begin
        d        = q;
        d.s1_vld = 1'b0;
        if (in_valid && in_ready) begin
            d.s1_vld   = 1'b1;
            d.s1_last  = in_last;
            d.s1_first = q.fresh;
            d.fresh    = 1'b0;
            d.pt       = '{x: in_x, y: in_y, invz: in_invz, amp: in_amp};
            if (q.fresh) begin
                d.ox = org_x;
                d.oy = org_y;
            end
        end
        if (q.s1_vld) begin
            for (int p = 0; p < NPIX; p++) begin
                d.acc_re[p] = q.s1_first ? AW'(c_re[p]) : sat_add($signed(q.acc_re[p]), c_re[p]);
                d.acc_im[p] = q.s1_first ? AW'(c_im[p]) : sat_add($signed(q.acc_im[p]), c_im[p]);
            end
            if (q.s1_last) begin
                d.st     = ST_READ;
                d.rd_idx = '0;
            end
        end
        if (q.st == ST_READ && out_ready) begin
            if (q.rd_idx == IDXW'(NPIX - 1)) begin
                d.st    = ST_ACCEPT;
                d.fresh = 1'b1;
            end else begin
                d.rd_idx = q.rd_idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.fresh <= 1'b1;
        end else begin
            q <= d;
        end
    end

    AST_NO_ACCEPT_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_READ) |-> !in_ready); // R8
    AST_DONE_TO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (q.s1_vld && q.s1_last) |=> out_valid); // R7
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im))); // R9
    AST_LAST_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (in_ready && !out_valid)); // R10
endmodule

// File: tb/sim_holo_tile_acc.sv
`timescale 1ns/1ps
module sim_holo_tile_acc;
    localparam int NP = 144;
    localparam int MAXPTS = 160;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
    logic in_ready, out_valid, out_last;
    logic signed [11:0] in_x = '0, in_y = '0, org_x = '0, org_y = '0;
    logic [15:0] in_invz = '0;
    logic [7:0]  in_amp = '0;
    logic signed [23:0] out_re, out_im;

    int errors = 0;
    int checks = 0;

    int pt_x [MAXPTS], pt_y [MAXPTS], pt_z [MAXPTS], pt_a [MAXPTS];
    longint exp_re [NP], exp_im [NP], got_re [NP], got_im [NP];

    always #2.5 clk = ~clk;

    holo_tile_acc u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_x(in_x), .in_y(in_y), .in_invz(in_invz), .in_amp(in_amp), .in_last(in_last),
        .org_x(org_x), .org_y(org_y), .out_valid(out_valid), .out_ready(out_ready),
        .out_re(out_re), .out_im(out_im), .out_last(out_last)
    );

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int wrap12(input int v);
        int w;
        w = v & 4095;
        return (w >= 2048) ? w - 4096 : w;
    endfunction

    function automatic longint qwv(input int t);
        return (longint'(t) * (512 - t) * 32767) >>> 16;
    endfunction

    function automatic longint sinv(input int p);
        int qd, i;
        longint m;
        qd = (p >> 8) & 3;
        i  = p & 255;
        m  = (qd & 1) ? qwv(255 - i) : qwv(i);
        return (qd & 2) ? -m : m;
    endfunction

    function automatic longint sat24(input longint v);
        if (v > 8388607) return 8388607;
        if (v < -8388608) return -8388608;
        return v;
    endfunction

    // R2 R3 R4 R5 R6 reference accumulation
    task automatic build_expected(input int n, input int ox, input int oy);
        for (int k = 0; k < NP; k++) begin
            int r, c, dx, dy, ph;
            longint d2, prod, vr, vi;
            r = k / 12;
            c = k % 12;
            for (int i = 0; i < n; i++) begin
                dx   = wrap12(ox + c) - pt_x[i];
                dy   = wrap12(oy + r) - pt_y[i];
                d2   = longint'(dx) * dx + longint'(dy) * dy;
                prod = d2 * pt_z[i];
                ph   = int'((prod >>> 16) & 1023);
                vr   = (longint'(pt_a[i]) * sinv((ph + 256) & 1023)) >>> 7;
                vi   = (longint'(pt_a[i]) * sinv(ph)) >>> 7;
                if (i == 0) begin
                    exp_re[k] = vr;
                    exp_im[k] = vi;
                end else begin
                    exp_re[k] = sat24(exp_re[k] + vr);
                    exp_im[k] = sat24(exp_im[k] + vi);
                end
            end
        end
    endtask

    task automatic run_tile(input int n, input int ox, input int oy, input bit stall, input string tag);
        int i;
        int k;
        bit acc;
        bit rdy;
        build_expected(n, ox, oy);
        i = 0;
        while (i < n) begin
            in_valid = 1'b1;
            in_x = 12'(pt_x[i]);
            in_y = 12'(pt_y[i]);
            in_invz = 16'(pt_z[i]);
            in_amp = 8'(pt_a[i]);
            in_last = (i == n - 1);
            // R11: origin only meaningful with the first point
            org_x = (i == 0) ? 12'(ox) : 12'($urandom);
            org_y = (i == 0) ? 12'(oy) : 12'($urandom);
            acc = in_ready;
            @(negedge clk);
            if (acc) i++;
        end
        in_valid = 1'b0;
        in_last = 1'b0;
        chk(!in_ready, "R8", {tag, " in_ready after last"}, in_ready, 0);
        chk(!out_valid, "R7", {tag, " out_valid one edge after last"}, out_valid, 0);
        @(negedge clk);
        chk(out_valid, "R7", {tag, " out_valid two edges after last"}, out_valid, 1);
        k = 0;
        while (k < NP) begin
            chk(out_valid, "R9", {tag, " valid during readout"}, out_valid, 1);
            chk(!in_ready, "R8", {tag, " in_ready during readout"}, in_ready, 0);
            chk(out_re == exp_re[k], "R4", $sformatf("%s re pixel %0d", tag, k), out_re, exp_re[k]);
            chk(out_im == exp_im[k], "R3", $sformatf("%s im pixel %0d", tag, k), out_im, exp_im[k]);
            chk(out_last == (k == NP - 1), "R10", $sformatf("%s last flag pixel %0d", tag, k), out_last, k == NP - 1);
            got_re[k] = out_re;
            got_im[k] = out_im;
            rdy = stall ? (($urandom % 3) != 0) : 1'b1;
            out_ready = rdy;
            @(negedge clk);
            if (rdy) k++;
        end
        out_ready = 1'b0;
        chk(in_ready, "R10", {tag, " in_ready after readout"}, in_ready, 1);
        chk(!out_valid, "R10", {tag, " out_valid after readout"}, out_valid, 0);
    endtask

    task automatic test_reset();
        chk(!out_valid, "R1", "reset out_valid", out_valid, 0);
        chk(in_ready, "R1", "reset in_ready", in_ready, 1);
    endtask

    task automatic test_random(input int n, input bit stall, input string tag);
        for (int i = 0; i < n; i++) begin
            pt_x[i] = int'($urandom % 200) - 100;
            pt_y[i] = int'($urandom % 200) - 100;
            pt_z[i] = int'($urandom % 65536);
            pt_a[i] = int'($urandom % 256);
        end
        // R2 R5 R11: varied origins, each tile independent of the previous one
        run_tile(n, int'($urandom % 256) - 128, int'($urandom % 256) - 128, stall, tag);
    endtask

    task automatic test_wrap();
        for (int i = 0; i < 4; i++) begin
            pt_x[i] = 2040 - i;
            pt_y[i] = -2045 + i;
            pt_z[i] = 3000 + 1000 * i;
            pt_a[i] = 200;
        end
        // R2: origin near the positive limit so pixel coordinates wrap
        run_tile(4, 2043, -2047, 1'b0, "wrap");
    endtask

    task automatic test_saturation();
        for (int i = 0; i < 130; i++) begin
            pt_x[i] = 0;
            pt_y[i] = 0;
            pt_z[i] = 0;
            pt_a[i] = 255;
        end
        run_tile(130, 0, 0, 1'b0, "sat");
        chk(got_re[0] == 8388607, "R6", "saturated real", got_re[0], 8388607);
        chk(got_im[77] == 0, "R6", "zero imaginary", got_im[77], 0);
    endtask

    task automatic test_symmetry();
        pt_x[0] = 15;
        pt_y[0] = 3;
        pt_z[0] = 40000;
        pt_a[0] = 180;
        run_tile(1, 10, -2, 1'b1, "sym");
        for (int r = 0; r < 12; r++) begin
            for (int a = 1; a <= 5; a++) begin
                chk(got_re[r*12+5-a] == got_re[r*12+5+a], "R12", $sformatf("re mirror r%0d a%0d", r, a),
                    got_re[r*12+5-a], got_re[r*12+5+a]);
                chk(got_im[r*12+5-a] == got_im[r*12+5+a], "R12", $sformatf("im mirror r%0d a%0d", r, a),
                    got_im[r*12+5-a], got_im[r*12+5+a]);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_random(7, 1'b0, "rand_a");
        test_random(20, 1'b1, "rand_b");
        test_random(1, 1'b1, "rand_c");
        test_wrap();
        test_saturation();
        test_symmetry();
        test_random(12, 1'b0, "rand_d");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule